// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block gathers level alarm signals from several functional sub-blocks, such as a line interface, a framer and a link-layer controller. Each sub-block owns one sticky status register, with one bit per alarm. A bit latches when its alarm turns on and keeps that value until the host has read it and the alarm has gone away. A per-bit mask keeps chosen alarms out of the interrupt path, but those alarms still latch their status. A global source register has one bit per sub-block. It shows which sub-blocks hold unmasked pending status.

The host can work in interrupt-driven mode or in polled mode. In interrupt-driven mode, the single interrupt output pulses high once for each new unmasked activation. It stays high until the host reads the global register and then the status register of every sub-block flagged there. In polled mode, the host sets all masks and reads the status registers directly. The same conditional clear-on-read rule applies in both modes.

Register map (address, default sizes):
- Address 0 is the global register (read only).
- Address 1+b is the status register of sub-block b.
- Address 16+b is the mask register of sub-block b.

Alarm inputs are asynchronous. Each alarm input passes through a two-stage synchronizer, so an activation reaches its status bit on the third rising clock edge after the input changes.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, the following are all zero: every status register, every mask register, the global register and `irq_o`.
- R2: A 0-to-1 transition on alarm bit i of sub-block b sets bit i of the status register at address 1+b on the third rising clock edge after the input change. Bit j of `alarm_i` belongs to sub-block j/ALM_W, position j%ALM_W.
- R3: A set status bit stays set after its alarm returns to 0, until a status read clears it.
- R4: A read of status register 1+b clears exactly those set bits whose synchronized alarm is 0. Bits whose alarm is still 1 stay set. An activation in the same cycle as the read wins over the clear.
- R5: A write to address 16+b loads the mask of sub-block b, and a read of that address returns it. A masked alarm still latches its status bit, but it never raises `irq_o` and never shows in the global register.
- R6: Bit b of the global register (address 0) is 1 exactly when sub-block b has a status bit set whose mask bit is 0. Reading the global register clears nothing.
- R7: `irq_o` rises on the clock edge at which an unmasked activation latches. An alarm that stays active does not raise `irq_o` again after it has been serviced.
- R8: `irq_o` falls only after two steps, in this order: a read of the global register, then reads of the status register of every sub-block whose global bit was 1 at that read. Status reads made before the global read do not count toward this.
- R9: A new unmasked activation that arrives while the interrupt is being serviced keeps `irq_o` high and restarts the service sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_i | input | N_BLK*ALM_W | Level alarm inputs, grouped by sub-block |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| wr_stb | input | 1 | Write strobe, one cycle per write (mask registers only) |
| addr | input | ADDR_W | Register address |
| wdata | input | ALM_W | Write data |
| rdata | output | ALM_W | Read data, combinational from `addr` |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume the following about the inputs:
- Each read lasts one cycle.
- Each alarm level stays stable long enough for the synchronizer to see every edge.
- A clear can only follow a read strobe, so any bit that drops without a read means the design is wrong.

The stimulus keeps within these limits. It changes alarms only on the falling clock edge and holds each level for at least four cycles before it reads. It issues reads and writes as single-cycle pulses with idle cycles between them. It never changes a mask in the middle of a service sequence.

// File: rtl/aic_pkg.sv
package aic_pkg;
  // Register map offsets shared by the decoder and its users
  localparam int unsigned GBL_OFS  = 0;
  localparam int unsigned STAT_OFS = 1;
  localparam int unsigned MASK_OFS = 16;
endpackage

// File: rtl/aic_sync.sv
module aic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/aic_bank.sv
module aic_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise,
  input  logic         rd_clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  output logic [W-1:0] sticky,
  output logic [W-1:0] mask,
  output logic         pend
);
  // Activation always wins; a read only clears bits whose alarm is gone
  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] cur,
                                               input logic [W-1:0] act,
                                               input logic [W-1:0] level,
                                               input logic         rd);
    logic [W-1:0] clr;
    clr = {W{rd}} & ~level;
    return act | (cur & ~clr);
  endfunction

  function automatic logic pend_of(input logic [W-1:0] st, input logic [W-1:0] mk);
    return |(st & ~mk);
  endfunction

  logic [W-1:0] sticky_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= sticky_next(sticky_q, rise, lvl, rd_clr);
      if (mask_we) mask_q <= mask_wd;
    end
  end

  assign sticky = sticky_q;
  assign mask   = mask_q;
  assign pend   = pend_of(sticky_q, mask_q);
endmodule

// File: rtl/aic_irq.sv
module aic_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         new_evt,
  input  logic         gbl_rd,
  input  logic [N-1:0] blk_rd,
  input  logic [N-1:0] gbl,
  output logic         irq,
  output logic         armed
);
  logic         irq_q, armed_q;
  logic [N-1:0] svc_q;
  logic         done;

  // Service is complete once armed by a global read and every flagged block is read
  assign done = armed_q && (svc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
      svc_q   <= '0;
    end else if (new_evt) begin
      irq_q   <= 1'b1;
      armed_q <= 1'b0;
      svc_q   <= '0;
    end else if (done) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
      svc_q   <= '0;
    end else if (gbl_rd && irq_q) begin
      armed_q <= 1'b1;
      svc_q   <= gbl;
    end else begin
      svc_q   <= svc_q & ~blk_rd;
    end
  end

  assign irq   = irq_q;
  assign armed = armed_q;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import aic_pkg::*;
#(
  parameter int N_BLK  = 3,
  parameter int ALM_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_BLK*ALM_W-1:0] alarm_i,
  input  logic                   rd_stb,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [ALM_W-1:0]       wdata,
  output logic [ALM_W-1:0]       rdata,
  output logic                   irq_o
);
  localparam int TOT = N_BLK * ALM_W;

  function automatic logic unmasked_rise(input logic [TOT-1:0] r, input logic [TOT-1:0] m);
    return |(r & ~m);
  endfunction

  logic [TOT-1:0]   lvl_flat, rise_flat, sticky_flat, mask_flat;
  logic [N_BLK-1:0] gbl, stat_hit, mask_hit, stat_rd;
  logic             gbl_hit, gbl_rd, new_evt, armed;

  aic_sync #(.W(TOT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (alarm_i),
    .lvl  (lvl_flat),
    .rise (rise_flat)
  );

  assign gbl_hit = (addr == ADDR_W'(GBL_OFS));
  assign gbl_rd  = rd_stb & gbl_hit;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    assign stat_hit[b] = (addr == ADDR_W'(STAT_OFS + b));
    assign mask_hit[b] = (addr == ADDR_W'(MASK_OFS + b));
    assign stat_rd[b]  = rd_stb & stat_hit[b];

    aic_bank #(.W(ALM_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_flat[b*ALM_W +: ALM_W]),
      .rise   (rise_flat[b*ALM_W +: ALM_W]),
      .rd_clr (stat_rd[b]),
      .mask_we(wr_stb & mask_hit[b]),
      .mask_wd(wdata),
      .sticky (sticky_flat[b*ALM_W +: ALM_W]),
      .mask   (mask_flat[b*ALM_W +: ALM_W]),
      .pend   (gbl[b])
    );
  end

  assign new_evt = unmasked_rise(rise_flat, mask_flat);

  aic_irq #(.N(N_BLK)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .new_evt(new_evt),
    .gbl_rd (gbl_rd),
    .blk_rd (stat_rd),
    .gbl    (gbl),
    .irq    (irq_o),
    .armed  (armed)
  );

  always_comb begin
    rdata = '0;
    if (gbl_hit) rdata = ALM_W'(gbl);
    for (int b = 0; b < N_BLK; b++) begin
      if (stat_hit[b]) rdata = rdata | sticky_flat[b*ALM_W +: ALM_W];
      if (mask_hit[b]) rdata = rdata | mask_flat[b*ALM_W +: ALM_W];
    end
  end
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int N_BLK = 3,
  parameter int ALM_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_stb,
  input logic                   irq_o,
  input logic                   new_evt,
  input logic                   armed,
  input logic [N_BLK*ALM_W-1:0] sticky,
  input logic [N_BLK*ALM_W-1:0] mask,
  input logic [N_BLK*ALM_W-1:0] lvl,
  input logic [N_BLK*ALM_W-1:0] rise
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (irq_o == 1'b0 && sticky == '0 && mask == '0)
        else $error("R1 state not clear in reset");
    end
  end

  assert_rise_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((sticky & $past(rise)) == $past(rise)));

  assert_drop_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sticky) & ~sticky) != '0) |-> $past(rd_stb));

  assert_no_clear_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sticky) & ~sticky & $past(lvl)) == '0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && ((rise & ~mask) == '0)) |=> !irq_o);

  assert_irq_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(new_evt));

  assert_fall_after_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(armed));

  assert_event_holds_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    new_evt |=> irq_o);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.N_BLK(N_BLK), .ALM_W(ALM_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_stb (rd_stb),
  .irq_o  (irq_o),
  .new_evt(new_evt),
  .armed  (armed),
  .sticky (sticky_flat),
  .mask   (mask_flat),
  .lvl    (lvl_flat),
  .rise   (rise_flat)
);

// File: tb/alarm_irq_ctrl_bench.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_bench;
  localparam int NB  = 3;
  localparam int AW  = 8;
  localparam int ADW = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NB*AW-1:0] alarm;
  logic            rd_stb, wr_stb;
  logic [ADW-1:0]  addr;
  logic [AW-1:0]   wdata;
  logic [AW-1:0]   rdata;
  logic            irq_o;
  logic [AW-1:0]   rv;
  int              errs = 0;
  int              checks = 0;
  bit              done = 0;

  always #2 clk = ~clk;

  alarm_irq_ctrl #(.N_BLK(NB), .ALM_W(AW), .ADDR_W(ADW)) u_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [AW-1:0] d);
    @(negedge clk);
    rd_stb = 1'b1;
    addr   = ADW'(a);
    #1 d = rdata;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr(input int a, input logic [AW-1:0] v);
    @(negedge clk);
    wr_stb = 1'b1;
    addr   = ADW'(a);
    wdata  = v;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_alarm(input int b, input int i, input logic v);
    @(negedge clk);
    alarm[b*AW + i] = v;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; alarm = '0; rd_stb = 1'b0; wr_stb = 1'b0; addr = '0; wdata = '0;
    idle(3);
    chk("R1 irq in reset", 32'(irq_o), 0);
    rst_n = 1'b1;
    idle(2);
    rd(0, rv); chk("R1 global", 32'(rv), 0);
    for (int b = 0; b < NB; b++) begin
      rd(1 + b, rv);  chk("R1 status", 32'(rv), 0);
      rd(16 + b, rv); chk("R1 mask", 32'(rv), 0);
    end
    chk("R1 irq after reset", 32'(irq_o), 0);

    // Sweep every alarm bit with interrupts enabled
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < AW; i++) begin
        set_alarm(b, i, 1'b1);
        idle(4);
        chk("R7 irq on activation", 32'(irq_o), 1);
        rd(0, rv); chk("R6 global bit", 32'(rv), 32'(1 << b));
        rd(0, rv); chk("R6 global read does not clear", 32'(rv), 32'(1 << b));
        rd(1 + b, rv); chk("R2 status latched", 32'(rv), 32'(1 << i));
        rd(1 + b, rv); chk("R4 active bit kept", 32'(rv), 32'(1 << i));
        idle(2);
        chk("R8 irq released after service", 32'(irq_o), 0);
        idle(6);
        chk("R7 no repeat while active", 32'(irq_o), 0);
        set_alarm(b, i, 1'b0);
        idle(4);
        chk("R3 irq stays low on drop", 32'(irq_o), 0);
        rd(1 + b, rv); chk("R3 bit held after drop", 32'(rv), 32'(1 << i));
        rd(1 + b, rv); chk("R4 inactive bit cleared", 32'(rv), 0);
      end
    end

    // Service order: block read before global read does not count
    set_alarm(0, 0, 1'b1);
    set_alarm(2, 1, 1'b1);
    idle(4);
    chk("R7 irq two blocks", 32'(irq_o), 1);
    rd(1, rv); chk("R2 block0 status", 32'(rv), 1);
    idle(2);
    chk("R8 early block read ignored", 32'(irq_o), 1);
    rd(0, rv); chk("R6 two-block global", 32'(rv), 32'h5);
    rd(1, rv);
    idle(2);
    chk("R8 waits for block2", 32'(irq_o), 1);
    rd(3, rv); chk("R2 block2 status", 32'(rv), 2);
    idle(2);
    chk("R8 released after both", 32'(irq_o), 0);
    set_alarm(0, 0, 1'b0);
    set_alarm(2, 1, 1'b0);
    idle(4);
    rd(1, rv); rd(3, rv);
    rd(0, rv); chk("R4 all cleared", 32'(rv), 0);

    // New activation during service
    set_alarm(1, 3, 1'b1);
    idle(4);
    rd(0, rv); chk("R6 block1 flagged", 32'(rv), 2);
    set_alarm(1, 4, 1'b1);
    idle(4);
    rd(2, rv); chk("R9 both bits latched", 32'(rv), 32'h18);
    idle(2);
    chk("R9 irq kept by new event", 32'(irq_o), 1);
    rd(0, rv); rd(2, rv);
    idle(2);
    chk("R9 released after restart", 32'(irq_o), 0);
    set_alarm(1, 3, 1'b0);
    set_alarm(1, 4, 1'b0);
    idle(4);
    rd(2, rv);
    rd(2, rv); chk("R4 block1 cleared", 32'(rv), 0);

    // Polled mode: everything masked
    for (int b = 0; b < NB; b++) begin
      wr(16 + b, 8'hFF);
      rd(16 + b, rv); chk("R5 mask readback", 32'(rv), 32'hFF);
    end
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < AW; i++) begin
        set_alarm(b, i, 1'b1);
        idle(4);
        chk("R5 masked no irq", 32'(irq_o), 0);
        rd(0, rv); chk("R5 masked not in global", 32'(rv), 0);
        set_alarm(b, i, 1'b0);
        idle(4);
        rd(1 + b, rv); chk("R5 masked still latches", 32'(rv), 32'(1 << i));
        rd(1 + b, rv); chk("R4 polled clear", 32'(rv), 0);
      end
    end

    // Partial mask on block 0
    wr(16, 8'hAA);
    rd(16, rv); chk("R5 partial mask readback", 32'(rv), 32'hAA);
    set_alarm(0, 1, 1'b1);
    idle(4);
    chk("R5 masked bit1 no irq", 32'(irq_o), 0);
    set_alarm(0, 0, 1'b1);
    idle(4);
    chk("R7 unmasked bit0 irq", 32'(irq_o), 1);
    rd(0, rv); chk("R6 partial global", 32'(rv), 1);
    rd(1, rv); chk("R2 both bits", 32'(rv), 3);
    idle(2);
    chk("R8 released partial", 32'(irq_o), 0);

    done = 1;
    summary();
  end
endmodule